// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from one of two source clocks: the on-chip bus clock or an externally supplied display clock. The source is divided by a programmable 12-bit ratio with four fractional bits. A phase accumulator chooses between the floor and the ceiling of the ratio for each output period, so the long-run average period equals the programmed ratio exactly.

Within each output period, the rising and falling edges of the pixel clock sit at programmable positions counted in half source cycles. An optional inversion is applied at the output. A one-source-cycle tick marks the first cycle of every output period, so that downstream horizontal and vertical timing counters can advance in step with the pixel clock.

Configuration is written through a simple register port clocked by the bus clock. The control pins are plain and carry no handshake. The configuration is treated as quasi-static: software changes it while the display is idle, and the first few periods after a change may be irregular.

Top module: `pixclk_frac_div`

## Requirements
- R1: The ratio register at address 1 holds the ratio in bits 11:0, and its low 4 bits are the fraction. Each output period lasts either the integer part or the integer part plus one source cycles. When the fraction is zero, every period lasts exactly the integer part.
- R2: Any 16 consecutive output periods with a fixed ratio together last exactly 16 × integer part + fraction source cycles.
- R3: A ratio below 0x010 behaves as 0x010, which gives output periods of one source cycle.
- R4: After reset, the state is:
  - ratio 0x010;
  - rise position 0 and fall position 1;
  - bus clock selected, no inversion.

  The pixel clock then runs at the bus clock rate and is high in the first half of each cycle.
- R5: The edge register at address 2 holds the rise position in bits 8:0 and the fall position in bits 24:16. Both positions are counted in half source cycles from the start of the period. The output goes high at the rise half and low at the fall half. With rise < fall < 2 × period, it is high for (fall − rise) half cycles, starting rise half cycles into the period.
- R6: With rise 0 and fall equal to the integer ratio, an integer ratio gives a 50% duty cycle.
- R7: When rise equals fall, the fall wins and the output stays low for the whole period.
- R8: In the control register at address 0, bit 20 set selects clk_ext as the source, and bit 20 clear selects clk_bus.
- R9: In the control register, bit 17 set inverts pix_clk.
- R10: period_tick is high for exactly one source cycle, and that cycle is the first cycle of each output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; clocks the register port; internal source option |
| clk_ext | input | 1 | External display clock; source option |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_we | input | 1 | Register write strobe, sampled on clk_bus |
| cfg_addr | input | 2 | Register address: 0 control, 1 ratio, 2 edges |
| cfg_wdata | input | 32 | Register write data |
| pix_clk | output | 1 | Generated pixel clock |
| period_tick | output | 1 | One-source-cycle pulse at the start of each period |

## Verification
The hardest situation to reach from the ports is the fractional accumulator carrying in a pattern that breaks the alternation between floor and ceiling lengths. That breakage only shows in the exact total over a full 16-period window. The stimulus programs fractions from 0 to 15, mixing directed values with random ones drawn under a fixed seed. After each change it lets the output settle, then measures 16 consecutive periods in time units on a fine grid. This also exposes the half-cycle edge placement and the choice of source clock, because the two clocks have different periods.

// File: rtl/pclk_div_pkg.sv
`timescale 1ns/1ps
package pclk_div_pkg;
  // register addresses on the configuration port
  localparam logic [1:0] CFG_CTRL  = 2'd0;
  localparam logic [1:0] CFG_RATIO = 2'd1;
  localparam logic [1:0] CFG_EDGE  = 2'd2;
  // control register bit positions
  localparam int SRC_EXT_BIT = 20;
  localparam int INVERT_BIT  = 17;
  // edge register field offsets
  localparam int RISE_LSB = 0;
  localparam int FALL_LSB = 16;
  localparam int WDATA_W  = 32;
endpackage

// File: rtl/pclk_cfg_regs.sv
`timescale 1ns/1ps
module pclk_cfg_regs
  import pclk_div_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4,
  parameter int EDGE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [WDATA_W-1:0]  wr_data,
  output logic [DIV_W-1:0]    ratio,
  output logic [EDGE_W-1:0]   rise_pos,
  output logic [EDGE_W-1:0]   fall_pos,
  output logic                use_ext,
  output logic                invert
);
  localparam logic [DIV_W-1:0]  RATIO_RST = DIV_W'(1) << FRAC_W;
  localparam logic [EDGE_W-1:0] FALL_RST  = EDGE_W'(1);

  wire unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio    <= RATIO_RST;
      rise_pos <= '0;
      fall_pos <= FALL_RST;
      use_ext  <= 1'b0;
      invert   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        CFG_CTRL: begin
          use_ext <= wr_data[SRC_EXT_BIT];
          invert  <= wr_data[INVERT_BIT];
        end
        CFG_RATIO: ratio <= wr_data[DIV_W-1:0];
        CFG_EDGE: begin
          rise_pos <= wr_data[RISE_LSB +: EDGE_W];
          fall_pos <= wr_data[FALL_LSB +: EDGE_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pclk_phase_acc.sv
`timescale 1ns/1ps
module pclk_phase_acc #(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4,
  localparam int INT_W = DIV_W - FRAC_W,
  localparam int CNT_W = INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick
);
  localparam int LEN_W = INT_W + 1;
  localparam logic [DIV_W-1:0] RATIO_MIN = DIV_W'(1) << FRAC_W;

  logic [DIV_W-1:0] ratio_eff;
  logic [INT_W-1:0] int_part;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q, len_n;
  logic             wrap, carry, tick_q;

  assign ratio_eff = (ratio < RATIO_MIN) ? RATIO_MIN : ratio;
  assign int_part  = ratio_eff[DIV_W-1:FRAC_W];
  assign wrap      = (LEN_W'(cnt_q) + LEN_W'(1)) >= len_q;

  generate
    if (FRAC_W > 0) begin : g_frac
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   acc_sum;
      assign acc_sum = {1'b0, acc_q} + {1'b0, ratio_eff[FRAC_W-1:0]};
      assign carry   = acc_sum[FRAC_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc_q <= '0;
        else if (wrap) acc_q <= acc_sum[FRAC_W-1:0];
      end
    end else begin : g_int
      assign carry = 1'b0;
    end
  endgenerate

  assign len_n   = LEN_W'(int_part) + LEN_W'(carry);
  assign cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= LEN_W'(1);
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_q <= wrap;
      if (wrap) len_q <= len_n;
    end
  end

  assign cnt  = cnt_q;
  assign tick = tick_q;

  // R1: the cycle counter never reaches the current period length
  p_cnt_below_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(cnt_q) < len_q);
  // R10: the tick marks the first cycle of a period
  p_tick_first_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> cnt_q == '0);
  // R1: a new period length is the floor or the ceiling of the ratio
  p_len_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && $stable(ratio)) |->
      (len_q == LEN_W'(int_part)) || (len_q == LEN_W'(int_part) + LEN_W'(1)));
  // R3: a period is never shorter than one cycle
  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0);
endmodule

// File: rtl/pclk_edge_gen.sv
`timescale 1ns/1ps
module pclk_edge_gen #(
  parameter int CNT_W  = 8,
  parameter int EDGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [EDGE_W-1:0] rise_pos,
  input  logic [EDGE_W-1:0] fall_pos,
  output logic              lvl_hi,
  output logic              lvl_lo
);
  localparam int H_W = (CNT_W + 1 > EDGE_W) ? CNT_W + 1 : EDGE_W;

  logic [H_W-1:0] half_a_n, half_b_n, half_a;
  logic           lvl_a_n, lvl_b_n, lvl_a_q, lvl_b_q, primed_q;

  function automatic logic step_level(input logic prev, input logic [H_W-1:0] h,
                                      input logic [EDGE_W-1:0] r,
                                      input logic [EDGE_W-1:0] f);
    if (h == H_W'(f))      return 1'b0;
    else if (h == H_W'(r)) return 1'b1;
    else                   return prev;
  endfunction

  assign half_a_n = H_W'({cnt_nxt, 1'b0});
  assign half_b_n = H_W'({cnt_nxt, 1'b1});
  assign half_a   = H_W'({cnt, 1'b0});

  always_comb begin
    lvl_a_n = step_level(lvl_b_q, half_a_n, rise_pos, fall_pos);
    lvl_b_n = step_level(lvl_a_n, half_b_n, rise_pos, fall_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_a_q  <= 1'b0;
      lvl_b_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lvl_a_q  <= lvl_a_n;
      lvl_b_q  <= lvl_b_n;
      primed_q <= 1'b1;
    end
  end

  assign lvl_hi = lvl_a_q;
  assign lvl_lo = lvl_b_q;

  // R7: the fall position forces the level low, even when it equals the rise
  p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(fall_pos) && half_a == H_W'(fall_pos)) |-> !lvl_a_q);
  // R5: the rise position sets the level
  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(rise_pos) && $stable(fall_pos) &&
     half_a == H_W'(rise_pos) && half_a != H_W'(fall_pos)) |-> lvl_a_q);
  // R5: away from both positions the level is held
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(rise_pos) && $stable(fall_pos) &&
     half_a != H_W'(rise_pos) && half_a != H_W'(fall_pos)) |-> lvl_a_q == $past(lvl_b_q));
endmodule

// File: rtl/pixclk_frac_div.sv
`timescale 1ns/1ps
module pixclk_frac_div
  import pclk_div_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4,
  parameter int EDGE_W = 9
) (
  input  logic        clk_bus,
  input  logic        clk_ext,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        pix_clk,
  output logic        period_tick
);
  localparam int CNT_W = DIV_W - FRAC_W;

  logic [DIV_W-1:0]  ratio;
  logic [EDGE_W-1:0] rise_pos, fall_pos;
  logic              use_ext, invert, src_clk, lvl_hi, lvl_lo;
  logic [CNT_W-1:0]  cnt, cnt_nxt;

  pclk_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) u_regs (
    .clk(clk_bus), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .ratio(ratio), .rise_pos(rise_pos),
    .fall_pos(fall_pos), .use_ext(use_ext), .invert(invert));

  assign src_clk = use_ext ? clk_ext : clk_bus;

  pclk_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_phase (
    .clk(src_clk), .rst_n(rst_n), .ratio(ratio), .cnt(cnt),
    .cnt_nxt(cnt_nxt), .tick(period_tick));

  pclk_edge_gen #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_edge (
    .clk(src_clk), .rst_n(rst_n), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .rise_pos(rise_pos), .fall_pos(fall_pos), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo));

  // the high phase of the source carries the even half, the low phase the odd half
  assign pix_clk = (src_clk ? lvl_hi : lvl_lo) ^ invert;
endmodule

// File: tb/pixclk_frac_div_tb.sv
`timescale 1ns/100ps
module pixclk_frac_div_tb;
  logic        clk_bus = 1'b0, clk_ext = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_clk, period_tick;

  pixclk_frac_div u_dut (
    .clk_bus(clk_bus), .clk_ext(clk_ext), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pix_clk(pix_clk),
    .period_tick(period_tick));

  always #2 clk_bus = ~clk_bus;   // 250 MHz
  always #3 clk_ext = ~clk_ext;

  int n_chk = 0, n_fail = 0;
  bit cur_sel = 1'b0;
  logic ref_clk;
  assign ref_clk = cur_sel ? clk_ext : clk_bus;
  bit edge_seen = 1'b0;
  always @(posedge ref_clk) edge_seen = 1'b1;

  int rec_len[64], rec_hi[64], rec_fhi[64], rec_flo[64], rec_tk[64];
  int nrec = 0;

  // 1 ns sampling grid, offset half a nanosecond from every clock edge
  initial begin : monitor
    int cnt, hi, fhi, flo, tk;
    bit started;
    cnt = 0; hi = 0; fhi = -1; flo = -1; tk = 0; started = 1'b0;
    #0.5;
    forever begin
      #1;
      if (edge_seen && period_tick) begin
        if (started) begin
          rec_len[nrec % 64] = cnt; rec_hi[nrec % 64] = hi;
          rec_fhi[nrec % 64] = fhi; rec_flo[nrec % 64] = flo;
          rec_tk[nrec % 64] = tk;
          nrec++;
        end
        cnt = 0; hi = 0; fhi = -1; flo = -1; tk = 0; started = 1'b1;
      end
      edge_seen = 1'b0;
      if (pix_clk) begin
        hi++;
        if (fhi < 0) fhi = cnt;
      end else if (flo < 0) flo = cnt;
      if (period_tick) tk++;
      cnt++;
    end
  end

  task automatic chk(input string req, input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk_bus);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input string tag, input bit prog, input bit sel, input bit inv,
                          input int d, input int r, input int fe);
    int th, tp, dc, ip, fp, act, sum, b0, base;
    if (prog) begin
      wr(2'd1, 32'(d));                        // R1 ratio register
      wr(2'd2, 32'((fe << 16) | r));           // R5 edge register
      wr(2'd0, 32'((int'(sel) << 20) | (int'(inv) << 17))); // R8 / R9
    end
    cur_sel = sel;
    th  = sel ? 3 : 2;
    tp  = 2 * th;
    dc  = (d < 16) ? 16 : d;                   // R3 clamp
    ip  = dc >> 4;
    fp  = dc & 15;
    act = (fe > r) ? fe - r : 0;               // R7: equal positions give no high time
    b0 = nrec;
    wait (nrec >= b0 + 3);
    base = nrec;
    wait (nrec >= base + 16);
    sum = 0;
    for (int i = 0; i < 16; i++) begin
      int k, l, a, fi;
      k = (base + i) % 64;
      l = rec_len[k];
      sum += l;
      chk("R1", tag, l, (fp != 0 && l == (ip + 1) * tp) ? l : ip * tp);
      a  = inv ? l - rec_hi[k] : rec_hi[k];
      fi = inv ? rec_flo[k] : rec_fhi[k];
      chk("R5", tag, a, act * th);
      chk("R5", tag, fi, (act > 0) ? r * th : -1);
      chk("R10", tag, rec_tk[k], tp);
    end
    chk("R2", tag, sum, (16 * ip + fp) * tp);
  endtask

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b1;
    run_case("R4 reset defaults", 1'b0, 1'b0, 1'b0, 16, 0, 1);
    run_case("R6 half duty 4.0", 1'b1, 1'b0, 1'b0, 'h40, 0, 4);
    run_case("R1 ratio 4.5", 1'b1, 1'b0, 1'b0, 'h48, 1, 5);
    run_case("R2 ratio 3.0625", 1'b1, 1'b0, 1'b0, 'h31, 2, 5);
    run_case("R2 ratio 2.9375", 1'b1, 1'b0, 1'b0, 'h2F, 0, 3);
    run_case("R3 below one", 1'b1, 1'b0, 1'b0, 'h0B, 0, 1);
    run_case("R7 equal edges", 1'b1, 1'b0, 1'b0, 'h30, 2, 2);
    run_case("R8 external source", 1'b1, 1'b1, 1'b0, 'h25, 0, 2);
    run_case("R9 inverted", 1'b1, 1'b0, 1'b1, 'h30, 1, 3);
    run_case("R8 back to bus", 1'b1, 1'b0, 1'b0, 'h1C, 0, 1);
    for (int i = 0; i < 8; i++) begin
      int d, ip, r, fe;
      bit sel, inv;
      d   = int'($urandom_range(8, 'hD0));
      ip  = ((d < 16) ? 16 : d) >> 4;
      r   = int'($urandom_range(0, 2 * ip - 2));
      fe  = int'($urandom_range(r + 1, 2 * ip - 1));
      sel = 1'($urandom_range(0, 1));
      inv = 1'($urandom_range(0, 1));
      run_case("random R1 R5 R8 R9", 1'b1, sel, inv, d, r, fe);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule